// File: doc/BRIEF.md
# DS3/E3 Transmit Frame Strobe Generator

This block runs on the transmit serial clock and tracks which bit of a DS3 M-frame or an E3 frame the serial data will carry. It produces one strobe on a shared output. That strobe can be a single-clock start-of-frame pulse or a payload data-enable. The strobe runs exactly three clocks ahead of the serial data. Upstream logic uses that lead to fetch payload bits and present them in time.

A mode input selects the frame structure:

- **DS3:** 7 subframes of 8 blocks. Each block is one overhead bit followed by 84 payload bits, giving 4760 bits per frame.
- **E3:** 1536 bits per frame. The first 12 bits are overhead and the rest are payload.

A function select chooses which strobe appears on the output. Mode and function changes are taken up only when a new frame starts, so a strobe is never cut short. A polarity control inverts the output. A build parameter retimes the output to the falling clock edge, for a downstream sampler that runs on the inverted clock.

Top module: `tx_frame_strobe`

## Requirements
- R1: `frame_mode` = 0 selects DS3 and 1 selects E3. In DS3 the frame is SUBFRAMES×BLOCKS blocks of 1 overhead bit plus PAYLOAD payload bits. In E3 the frame is E3_BITS long and its first E3_OVERHEAD bits are overhead.
- R2: With `strobe_fn` = 0 (start-of-frame), the raw strobe is high for exactly one clock in every frame, three clocks before frame bit 0 reaches the serial data.
- R3: With `strobe_fn` = 1 (data-enable), the raw strobe after a clock edge equals "bit is payload" for the frame bit that reaches the serial data three clocks later. It therefore rises three clocks before each payload run and falls three clocks before the run ends.
- R4: `strobe_inv` = 1 inverts the output. The output after each rising edge is the raw strobe XOR the `strobe_inv` value sampled at that edge.
- R5: While `rst` is high, and after the first two rising edges once `rst` is low, the raw strobe is low. The output then equals the sampled `strobe_inv`. The third edge after release announces frame bit 0, so a start-of-frame pulse follows that edge and bit 0 reaches the data three clocks later.
- R6: `frame_mode` and `strobe_fn` are sampled only at the edge that announces frame bit 0. Changes at any other time have no effect until the next frame starts.
- R7: With FALL_EDGE = 1, the output shows the same sequence, each value launched on the falling edge that follows the rising edge that produced it.
- R8: Frames repeat back to back without gaps. The bit after the last bit of a frame is bit 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit serial clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_mode | input | 1 | 0 = DS3 frame, 1 = E3 frame |
| strobe_fn | input | 1 | 0 = start-of-frame pulse, 1 = payload data-enable |
| strobe_inv | input | 1 | 1 inverts the output polarity |
| strobe_o | output | 1 | Shared frame strobe, three clocks ahead of the serial data |

## Verification
The bench builds the block with a reduced DS3 frame and a reduced E3 frame:

- **DS3:** 2 subframes of 3 blocks, each block 1 overhead bit plus 4 payload bits, giving a 30-bit frame.
- **E3:** a 20-bit frame whose first 3 bits are overhead.

With frames this short, every bit position, every block boundary and every frame wrap is visited many times within a few hundred clocks.

Mode and function are switched at arbitrary points so that both late and early switches arrive mid-frame. Together with polarity toggling and repeated resets, this covers the boundary-latching and start-up cases exhaustively.

A second instance built with FALL_EDGE = 1 runs next to the first, so the falling-edge variant is checked against the same expected sequence.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

    typedef enum logic {
        MODE_DS3 = 1'b0,
        MODE_E3  = 1'b1
    } frame_mode_e;

    typedef enum logic {
        FN_SOF = 1'b0,
        FN_DEN = 1'b1
    } strobe_fn_e;

    // Classification of the frame bit announced in the current cycle
    typedef struct packed {
        logic first;    // frame bit 0
        logic payload;  // payload (not overhead) bit
    } bit_class_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txfs_pos_counter.sv
module txfs_pos_counter
    import txfs_pkg::*;
#(
    parameter int LEAD      = 3,
    parameter int DS3_FRAME = 4760,
    parameter int DS3_BLK   = 85,
    parameter int E3_FRAME  = 1536,
    parameter int POS_W     = 13,
    parameter int BLK_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_mode_e       mode_i,
    output logic              run_o,
    output logic              boundary_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [BLK_W-1:0]  blk_o,
    output frame_mode_e       mode_o
);
    localparam int ARM_W = $clog2(LEAD + 1);
    localparam logic [ARM_W-1:0] ARM_DONE = ARM_W'(LEAD - 1);
    localparam logic [POS_W-1:0] DS3_LAST = POS_W'(DS3_FRAME - 1);
    localparam logic [POS_W-1:0] E3_LAST  = POS_W'(E3_FRAME - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(DS3_BLK - 1);

    logic [ARM_W-1:0] arm_q;
    logic [POS_W-1:0] pos_q;
    logic [BLK_W-1:0] blk_q;
    frame_mode_e      mode_q;
    frame_mode_e      cur_mode;
    logic             run;
    logic             last_bit;

    assign run      = (arm_q == ARM_DONE);
    assign cur_mode = (pos_q == '0) ? mode_i : mode_q;
    assign last_bit = (pos_q == ((cur_mode == MODE_DS3) ? DS3_LAST : E3_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= '0;
            pos_q  <= '0;
            blk_q  <= '0;
            mode_q <= MODE_DS3;
        end else if (!run) begin
            arm_q <= arm_q + 1'b1;
        end else begin
            mode_q <= cur_mode;
            if (last_bit) begin
                pos_q <= '0;
                blk_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
                blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
            end
        end
    end

    assign run_o      = run;
    assign boundary_o = run && (pos_q == '0);
    assign pos_o      = pos_q;
    assign blk_o      = blk_q;
    assign mode_o     = cur_mode;

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (pos_q != '0) |-> (pos_q <= ((mode_q == MODE_DS3) ? DS3_LAST : E3_LAST))); // R1

    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (pos_q == '0) |-> (blk_q == '0)); // R1

    AST_POS_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (run && pos_q != '0) |=> ((pos_q == $past(pos_q) + 1'b1) || (pos_q == '0))); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && pos_q > POS_W'(1)) |-> $stable(mode_q)); // R6

endmodule

// File: rtl/txfs_bit_class.sv
module txfs_bit_class
    import txfs_pkg::*;
#(
    parameter int POS_W       = 13,
    parameter int BLK_W       = 7,
    parameter int E3_OVERHEAD = 12
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [BLK_W-1:0] blk_i,
    input  frame_mode_e      mode_i,
    output bit_class_t       cls_o
);
    localparam logic [POS_W-1:0] E3_OH = POS_W'(E3_OVERHEAD);

    always_comb begin
        cls_o.first = (pos_i == '0);
        if (mode_i == MODE_DS3) begin
            cls_o.payload = (blk_i != '0);
        end else begin
            cls_o.payload = (pos_i >= E3_OH);
        end
    end

endmodule

// File: rtl/txfs_strobe_out.sv
module txfs_strobe_out
    import txfs_pkg::*;
#(
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run_i,
    input  logic        boundary_i,
    input  bit_class_t  cls_i,
    input  strobe_fn_e  fn_i,
    input  logic        inv_i,
    output logic        strobe_o
);
    strobe_fn_e fn_q;
    strobe_fn_e cur_fn;
    logic       raw_d;
    logic       raw_q;
    logic       inv_q;
    logic       line;

    assign cur_fn = boundary_i ? fn_i : fn_q;
    assign raw_d  = run_i && ((cur_fn == FN_SOF) ? cls_i.first : cls_i.payload);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            inv_q <= inv_i;
            fn_q  <= FN_SOF;
        end else begin
            raw_q <= raw_d;
            inv_q <= inv_i;
            if (run_i) begin
                fn_q <= cur_fn;
            end
        end
    end

    assign line = raw_q ^ inv_q;

    generate
        if (FALL_EDGE) begin : g_fall
            logic fall_q;
            always_ff @(negedge clk) begin
                fall_q <= line;
            end
            assign strobe_o = fall_q;
        end else begin : g_rise
            assign strobe_o = line;
        end
    endgenerate

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fn_q == FN_SOF && raw_q) |=> !raw_q); // R2

    AST_IDLE_UNTIL_RUN: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !raw_q); // R5

    AST_FN_HELD: assert property (@(posedge clk) disable iff (rst)
        (run_i && !boundary_i) |=> $stable(fn_q)); // R6

endmodule

// File: rtl/tx_frame_strobe.sv
module tx_frame_strobe
    import txfs_pkg::*;
#(
    parameter int DS3_SUBFRAMES = 7,
    parameter int DS3_BLOCKS    = 8,
    parameter int DS3_PAYLOAD   = 84,
    parameter int E3_BITS       = 1536,
    parameter int E3_OVERHEAD   = 12,
    parameter int LEAD          = 3,
    parameter bit FALL_EDGE     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_mode,
    input  logic strobe_fn,
    input  logic strobe_inv,
    output logic strobe_o
);
    localparam int DS3_BLK   = DS3_PAYLOAD + 1;
    localparam int DS3_FRAME = DS3_SUBFRAMES * DS3_BLOCKS * DS3_BLK;
    localparam int POS_W     = $clog2(max2(DS3_FRAME, E3_BITS));
    localparam int BLK_W     = $clog2(DS3_BLK);

    logic             run;
    logic             boundary;
    logic [POS_W-1:0] pos;
    logic [BLK_W-1:0] blk;
    frame_mode_e      cur_mode;
    bit_class_t       cls;

    txfs_pos_counter #(
        .LEAD      (LEAD),
        .DS3_FRAME (DS3_FRAME),
        .DS3_BLK   (DS3_BLK),
        .E3_FRAME  (E3_BITS),
        .POS_W     (POS_W),
        .BLK_W     (BLK_W)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (frame_mode_e'(frame_mode)),
        .run_o      (run),
        .boundary_o (boundary),
        .pos_o      (pos),
        .blk_o      (blk),
        .mode_o     (cur_mode)
    );

    txfs_bit_class #(
        .POS_W       (POS_W),
        .BLK_W       (BLK_W),
        .E3_OVERHEAD (E3_OVERHEAD)
    ) u_class (
        .pos_i  (pos),
        .blk_i  (blk),
        .mode_i (cur_mode),
        .cls_o  (cls)
    );

    txfs_strobe_out #(
        .FALL_EDGE (FALL_EDGE)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .boundary_i (boundary),
        .cls_i      (cls),
        .fn_i       (strobe_fn_e'(strobe_fn)),
        .inv_i      (strobe_inv),
        .strobe_o   (strobe_o)
    );

endmodule

// File: tb/tx_frame_strobe_bench.sv
module tx_frame_strobe_bench;
    localparam int SUB  = 2;
    localparam int BLKS = 3;
    localparam int PAY  = 4;
    localparam int E3F  = 20;
    localparam int E3OH = 3;
    localparam int DS3F = SUB * BLKS * (PAY + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic fn = 1'b0;
    logic inv = 1'b0;
    logic so;
    logic so_fall;

    always #4 clk = ~clk;

    tx_frame_strobe #(
        .DS3_SUBFRAMES (SUB), .DS3_BLOCKS (BLKS), .DS3_PAYLOAD (PAY),
        .E3_BITS (E3F), .E3_OVERHEAD (E3OH), .LEAD (3), .FALL_EDGE (1'b0)
    ) u_tx_frame_strobe (
        .clk (clk), .rst (rst), .frame_mode (mode), .strobe_fn (fn),
        .strobe_inv (inv), .strobe_o (so)
    );

    tx_frame_strobe #(
        .DS3_SUBFRAMES (SUB), .DS3_BLOCKS (BLKS), .DS3_PAYLOAD (PAY),
        .E3_BITS (E3F), .E3_OVERHEAD (E3OH), .LEAD (3), .FALL_EDGE (1'b1)
    ) u_tx_frame_strobe_fall (
        .clk (clk), .rst (rst), .frame_mode (mode), .strobe_fn (fn),
        .strobe_inv (inv), .strobe_o (so_fall)
    );

    int   vectors = 0;
    int   errs = 0;
    int   n = 0;
    int   mpos = 0;
    logic mmode = 1'b0;
    logic mfn = 1'b0;
    bit   done = 1'b0;

    function automatic int flen(logic m);
        return m ? E3F : DS3F;
    endfunction

    function automatic logic is_payload(int p, logic m);
        if (m) return (p >= E3OH);
        return ((p % (PAY + 1)) != 0);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: strobe=%b expected %b (cycle %0d, bit %0d)", tag, act, exp, n, mpos);
        end
    endtask

    // Applies one clock with the inputs already set; the model predicts the strobe
    task automatic step(string tag);
        logic  exp;
        logic  raw;
        string t;
        @(posedge clk);
        if (rst) begin
            n = 0;
            mpos = 0;
            exp = inv;
            t = "R5";
        end else begin
            n++;
            t = tag;
            if (n < 3) begin
                exp = inv;
                t = "R5";
            end else begin
                if (n == 3) t = "R5";
                if (mpos == 0) begin
                    mmode = mode;
                    mfn = fn;
                end
                raw = mfn ? is_payload(mpos, mmode) : (mpos == 0);
                exp = raw ^ inv;
                mpos++;
                if (mpos == flen(mmode)) mpos = 0;
            end
        end
        @(negedge clk);
        chk(t, so, exp);
        #3;
        chk("R7", so_fall, exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        // Reset state with inverted polarity
        inv = 1'b1;
        rst = 1'b1;
        repeat (3) step("R5");

        // Sweep all mode / function / polarity combinations from reset, R2 and R3
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int i = 0; i < 2; i++) begin
                    mode = m[0];
                    fn = f[0];
                    inv = i[0];
                    rst = 1'b1;
                    repeat (2) step("R5");
                    rst = 1'b0;
                    repeat (3 * DS3F) step(f ? "R3" : "R2");
                end
            end
        end

        // R1: frame length follows the mode, switched exactly at a boundary
        rst = 1'b1; mode = 1'b0; fn = 1'b1; inv = 1'b0;
        step("R5");
        rst = 1'b0;
        repeat (2 + DS3F) step("R1");
        mode = 1'b1;
        repeat (2 * E3F) step("R1");
        mode = 1'b0;
        repeat (2 * DS3F) step("R1");

        // R8: long back-to-back run in each mode
        repeat (10 * DS3F) step("R8");
        mode = 1'b1;
        fn = 1'b0;
        repeat (10 * E3F) step("R8");

        // R4: polarity toggled mid-frame
        for (int k = 0; k < 120; k++) begin
            if (k % 7 == 0) inv = ~inv;
            step("R4");
        end

        // R6: mode and function changed at arbitrary points inside frames
        for (int k = 0; k < 400; k++) begin
            if (k % 13 == 5) mode = ~mode;
            if (k % 17 == 3) fn = ~fn;
            step("R6");
        end

        // R5: reset mid-frame restarts the sequence
        repeat (11) step("R6");
        rst = 1'b1;
        step("R5");
        rst = 1'b0;
        repeat (DS3F + 6) step("R5");

        done = 1'b1;
        summary();
    end

endmodule